// File: doc/BRIEF.md
# I3C Target Enable/Disable Sequencer

This block decides when an I3C target controller really stops and restarts after software flips its enable control bit. Software writes the bit. The controller only goes down or comes back up when the bus allows it. A disable waits for an SDR transfer that is already in flight to end, for an HDR Exit pattern when the bus is in HDR mode, or for the next SCL rising edge when the bus is idle. A re-enable waits for a parameterised number of SCL rising edges, two by default. The status bit reports the real state, so software polls it after each write.

The block also controls access to the command, transmit and receive queues. A reset request is passed on as a flush only while the target is fully disabled or halted after an error. At any other time the request is ignored, so queued work survives a disable and resumes after re-enable. A disable requested while an in-band interrupt or a mastership request is pending is refused. The refusal is recorded in a sticky error flag.

SCL arrives asynchronously. It passes through a two-flop synchronizer, and only its rising edges count as bus activity. The protocol engines, the queues and the pattern detectors live elsewhere and appear here only as level flags and one-cycle strobes.

Top module: `i3c_tgt_en_seq`

## Requirements
- R1: A disable request is a 1-to-0 change of `sw_enable` between two consecutive clock samples. After an accepted request, `en_status` stays 1 until the disable completes. `en_status` is 0 only while the target is disabled or waiting to re-enable.
- R2: A request accepted in SDR mode (`hdr_mode`=0) while `xfer_active`=1 lets the transfer finish. `nack_new` is 1 from the next clock. The target becomes disabled on the clock that samples `xfer_done`=1.
- R3: A request accepted with `hdr_mode`=1 keeps `nack_new` at 0 and `en_status` at 1 until `hdr_exit` is sampled at 1. The target is disabled from the next clock.
- R4: A request accepted in SDR mode with no transfer active completes only on a synchronized SCL rising edge. The state changes on the third clock edge that samples `scl_in` high after a low sample. Without SCL activity, `en_status` stays 1 indefinitely.
- R5: `fifo_rst_ok` is 1 exactly when the target is disabled or `halt_err`=1. `fifo_flush` equals `fifo_rst_req` AND `fifo_rst_ok`. A reset request at any other time has no effect.
- R6: The block never raises `fifo_flush` by itself during a disable or an enable sequence, so queued commands and data are kept unless a reset is requested.
- R7: With `sw_enable`=1 in the disabled state, the target waits for EN_EDGES (default 2) synchronized SCL rising edges. `en_status` becomes 1 on the clock that counts the last edge. If `sw_enable` returns to 0 while waiting, the target goes back to disabled.
- R8: A disable request seen while `ibi_pending` or `mr_pending` is 1 is refused. The target stays enabled and `req_err` is set. `req_err` holds until the next 0-to-1 change of `sw_enable` clears it.
- R9: Setting `sw_enable` back to 1 while a disable is still pending cancels the disable on the next clock. `en_status` stays 1 and `nack_new` returns to 0.
- R10: While `rst_n` is sampled low, the target is placed in the disabled state with `en_status`=0 and `req_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_enable | input | 1 | Software enable control bit |
| scl_in | input | 1 | Raw asynchronous SCL line |
| xfer_active | input | 1 | SDR transfer in progress |
| xfer_done | input | 1 | One-cycle strobe at the end of an SDR transfer |
| hdr_mode | input | 1 | Bus is in HDR mode |
| hdr_exit | input | 1 | One-cycle strobe when an HDR Exit pattern is detected |
| halt_err | input | 1 | Target halted after a transmit/receive error |
| ibi_pending | input | 1 | In-band interrupt request pending |
| mr_pending | input | 1 | Mastership request pending |
| fifo_rst_req | input | 1 | Software request to reset the queues |
| en_status | output | 1 | Readable enable status |
| nack_new | output | 1 | NACK every newly addressed transfer |
| fifo_rst_ok | output | 1 | Queue reset is permitted |
| fifo_flush | output | 1 | Flush command to the queues |
| req_err | output | 1 | Sticky flag for a refused disable request |

## Verification
The assertions assume that `xfer_done` and `hdr_exit` are single-cycle strobes. They also assume that `xfer_done` comes only while a transfer is marked active and `hdr_exit` only while `hdr_mode` is 1. The stimulus keeps to this: it raises each strobe for exactly one clock inside a matching window. The assertions also assume that SCL changes slowly compared with the system clock. The bench holds each SCL level for four clocks, so every rising edge passes the synchronizer as a clean event.

// File: rtl/i3c_en_pkg.sv
package i3c_en_pkg;

  typedef enum logic [2:0] {
    ST_ON        = 3'd0,
    ST_DRAIN_SDR = 3'd1,
    ST_DRAIN_HDR = 3'd2,
    ST_IDLE_WAIT = 3'd3,
    ST_OFF       = 3'd4,
    ST_WAKE      = 3'd5
  } en_state_t;

  // Status reads 1 except when fully off or waking up.
  function automatic logic f_status(input en_state_t s);
    return !(s == ST_OFF || s == ST_WAKE);
  endfunction

  // New transfers are refused in every state except ON and the HDR drain.
  function automatic logic f_nack(input en_state_t s);
    return !(s == ST_ON || s == ST_DRAIN_HDR);
  endfunction

  // A disable cannot be accepted while a bus request is outstanding.
  function automatic logic f_blocked(input logic ibi, input logic mr);
    return ibi | mr;
  endfunction

endpackage

// File: rtl/i3c_scl_sync.sv
module i3c_scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  output logic scl_rise
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q[0] <= 1'b0;
    else        sh_q[0] <= scl_in;
  end

  for (genvar i = 1; i <= LAST; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) sh_q[i] <= 1'b0;
      else        sh_q[i] <= sh_q[i-1];
    end
  end

  assign scl_rise = sh_q[LAST-1] & ~sh_q[LAST];
endmodule

// File: rtl/i3c_en_req_detect.sv
module i3c_en_req_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_enable,
  output logic dis_req,
  output logic en_rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sw_enable;
  end

  assign dis_req = prev_q & ~sw_enable;
  assign en_rise = ~prev_q & sw_enable;
endmodule

// File: rtl/i3c_en_fsm.sv
module i3c_en_fsm
  import i3c_en_pkg::*;
#(
  parameter int EN_EDGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sw_enable,
  input  logic      dis_req,
  input  logic      en_rise,
  input  logic      scl_rise,
  input  logic      xfer_active,
  input  logic      xfer_done,
  input  logic      hdr_mode,
  input  logic      hdr_exit,
  input  logic      ibi_pending,
  input  logic      mr_pending,
  output en_state_t state,
  output logic      req_err
);
  localparam int CW = (EN_EDGES < 2) ? 1 : $clog2(EN_EDGES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(EN_EDGES - 1);

  en_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          refuse;

  assign refuse = dis_req & f_blocked(ibi_pending, mr_pending);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    err_d = err_q;
    if (en_rise) err_d = 1'b0;
    unique case (st_q)
      ST_ON: begin
        if (refuse) err_d = 1'b1;
        else if (dis_req) begin
          if (hdr_mode)         st_d = ST_DRAIN_HDR;
          else if (xfer_active) st_d = ST_DRAIN_SDR;
          else                  st_d = ST_IDLE_WAIT;
        end
      end
      ST_DRAIN_SDR: begin
        if (sw_enable)      st_d = ST_ON;
        else if (xfer_done) st_d = ST_OFF;
      end
      ST_DRAIN_HDR: begin
        if (sw_enable)     st_d = ST_ON;
        else if (hdr_exit) st_d = ST_OFF;
      end
      ST_IDLE_WAIT: begin
        if (sw_enable)     st_d = ST_ON;
        else if (scl_rise) st_d = ST_OFF;
      end
      ST_OFF: begin
        cnt_d = '0;
        if (sw_enable) st_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (!sw_enable) st_d = ST_OFF;
        else if (scl_rise) begin
          if (cnt_q == CNT_LAST) st_d = ST_ON;
          else                   cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign state   = st_q;
  assign req_err = err_q;
endmodule

// File: rtl/i3c_fifo_gate.sv
module i3c_fifo_gate
  import i3c_en_pkg::*;
(
  input  en_state_t state,
  input  logic      halt_err,
  input  logic      fifo_rst_req,
  output logic      fifo_rst_ok,
  output logic      fifo_flush
);
  assign fifo_rst_ok = (state == ST_OFF) | halt_err;
  assign fifo_flush  = fifo_rst_req & fifo_rst_ok;
endmodule

// File: rtl/i3c_tgt_en_seq.sv
module i3c_tgt_en_seq
  import i3c_en_pkg::*;
#(
  parameter int EN_EDGES    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_enable,
  input  logic scl_in,
  input  logic xfer_active,
  input  logic xfer_done,
  input  logic hdr_mode,
  input  logic hdr_exit,
  input  logic halt_err,
  input  logic ibi_pending,
  input  logic mr_pending,
  input  logic fifo_rst_req,
  output logic en_status,
  output logic nack_new,
  output logic fifo_rst_ok,
  output logic fifo_flush,
  output logic req_err
);
  logic      scl_rise;
  logic      dis_req;
  logic      en_rise;
  en_state_t state_q;

  i3c_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .scl_rise(scl_rise)
  );

  i3c_en_req_detect u_req (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable),
    .dis_req(dis_req), .en_rise(en_rise)
  );

  i3c_en_fsm #(.EN_EDGES(EN_EDGES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable),
    .dis_req(dis_req), .en_rise(en_rise), .scl_rise(scl_rise),
    .xfer_active(xfer_active), .xfer_done(xfer_done),
    .hdr_mode(hdr_mode), .hdr_exit(hdr_exit),
    .ibi_pending(ibi_pending), .mr_pending(mr_pending),
    .state(state_q), .req_err(req_err)
  );

  i3c_fifo_gate u_gate (
    .state(state_q), .halt_err(halt_err), .fifo_rst_req(fifo_rst_req),
    .fifo_rst_ok(fifo_rst_ok), .fifo_flush(fifo_flush)
  );

  assign en_status = f_status(state_q);
  assign nack_new  = f_nack(state_q);
endmodule

// File: rtl/i3c_tgt_en_seq_chk.sv
module i3c_tgt_en_seq_chk
  import i3c_en_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      sw_enable,
  input logic      scl_rise,
  input logic      dis_req,
  input logic      ibi_pending,
  input logic      mr_pending,
  input logic      halt_err,
  input logic      fifo_rst_req,
  input en_state_t state,
  input logic      en_status,
  input logic      nack_new,
  input logic      fifo_rst_ok,
  input logic      fifo_flush,
  input logic      req_err
);
  // R1: status only drops out of a pending-disable state
  a_r1_status_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_status) |-> ($past(state) == ST_DRAIN_SDR || $past(state) == ST_DRAIN_HDR
                          || $past(state) == ST_IDLE_WAIT));

  // R2: SDR drain refuses new transfers
  a_r2_sdr_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN_SDR) |-> nack_new);

  // R3: HDR drain keeps answering
  a_r3_hdr_no_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN_HDR) |-> (!nack_new && en_status));

  // R4: idle disable needs an SCL edge
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE_WAIT && !scl_rise && !sw_enable) |=> en_status);

  // R5: flush only when permitted
  a_r5_flush_gated: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (fifo_rst_ok && fifo_rst_req));

  // R5: permission only when off or halted
  a_r5_ok_cond: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst_ok |-> (!en_status || halt_err));

  // R7: no wake-up without SCL
  a_r7_wake_needs_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE && !scl_rise) |=> !en_status);

  // R8: refused disable keeps the target enabled and flags it
  a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ON && dis_req && (ibi_pending || mr_pending)) |=> (en_status && req_err && !nack_new));

  // R10: reset lands in the disabled state
  a_r10_reset: assert property (@(posedge clk)
    !rst_n |=> (!en_status && !req_err));
endmodule

bind i3c_tgt_en_seq i3c_tgt_en_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .scl_rise(scl_rise),
  .dis_req(dis_req), .ibi_pending(ibi_pending), .mr_pending(mr_pending),
  .halt_err(halt_err), .fifo_rst_req(fifo_rst_req), .state(state_q),
  .en_status(en_status), .nack_new(nack_new), .fifo_rst_ok(fifo_rst_ok),
  .fifo_flush(fifo_flush), .req_err(req_err)
);

// File: tb/i3c_tgt_en_seq_tb.sv
`timescale 1ns/1ps
module i3c_tgt_en_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n, sw_enable, scl_in, xfer_active, xfer_done, hdr_mode, hdr_exit;
  logic halt_err, ibi_pending, mr_pending, fifo_rst_req;
  logic en_status, nack_new, fifo_rst_ok, fifo_flush, req_err;

  always #4 clk = ~clk;

  i3c_tgt_en_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .scl_in(scl_in),
    .xfer_active(xfer_active), .xfer_done(xfer_done), .hdr_mode(hdr_mode),
    .hdr_exit(hdr_exit), .halt_err(halt_err), .ibi_pending(ibi_pending),
    .mr_pending(mr_pending), .fifo_rst_req(fifo_rst_req),
    .en_status(en_status), .nack_new(nack_new), .fifo_rst_ok(fifo_rst_ok),
    .fifo_flush(fifo_flush), .req_err(req_err)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Behavioural reference: mode names as integers
  localparam int M_ON = 0, M_SDR = 1, M_HDR = 2, M_IDLE = 3, M_OFF = 4, M_WAKE = 5;
  int m_mode = M_OFF;
  int m_edges = 0;
  int m_prev_en = 0;
  int m_err = 0;
  int scl_hist[$] = '{0, 0, 0};

  function automatic int bit_of(logic b);
    return (b === 1'b1) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic model_edge();
    int rise, en, fall, up;
    if (!rst_n) begin
      m_mode = M_OFF; m_edges = 0; m_prev_en = 0; m_err = 0;
      scl_hist = '{0, 0, 0};
      return;
    end
    rise = (scl_hist[1] == 1 && scl_hist[2] == 0) ? 1 : 0;
    en   = bit_of(sw_enable);
    fall = (m_prev_en == 1 && en == 0) ? 1 : 0;
    up   = (m_prev_en == 0 && en == 1) ? 1 : 0;
    if (up) m_err = 0;
    case (m_mode)
      M_ON:
        if (fall && (ibi_pending || mr_pending)) m_err = 1;
        else if (fall) m_mode = hdr_mode ? M_HDR : (xfer_active ? M_SDR : M_IDLE);
      M_SDR:  if (en) m_mode = M_ON; else if (xfer_done) m_mode = M_OFF;
      M_HDR:  if (en) m_mode = M_ON; else if (hdr_exit)  m_mode = M_OFF;
      M_IDLE: if (en) m_mode = M_ON; else if (rise)      m_mode = M_OFF;
      M_OFF:  begin m_edges = 0; if (en) m_mode = M_WAKE; end
      M_WAKE:
        if (!en) m_mode = M_OFF;
        else if (rise) begin
          m_edges++;
          if (m_edges == 2) m_mode = M_ON;
        end
      default: m_mode = M_OFF;
    endcase
    m_prev_en = en;
    scl_hist.push_front(bit_of(scl_in));
    void'(scl_hist.pop_back());
  endtask

  task automatic compare_all();
    int ok;
    ok = (m_mode == M_OFF || halt_err) ? 1 : 0;
    check("R1 en_status", bit_of(en_status), (m_mode == M_OFF || m_mode == M_WAKE) ? 0 : 1);
    check("R2 nack_new", bit_of(nack_new), (m_mode == M_ON || m_mode == M_HDR) ? 0 : 1);
    check("R5 fifo_rst_ok", bit_of(fifo_rst_ok), ok);
    check("R6 fifo_flush", bit_of(fifo_flush), (ok && fifo_rst_req) ? 1 : 0);
    check("R8 req_err", bit_of(req_err), m_err);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    cycles++;
    @(negedge clk);
    compare_all();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic scl_pulse();
    scl_in = 1'b1; steps(4);
    scl_in = 1'b0; steps(4);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 0; sw_enable = 0; scl_in = 0; xfer_active = 0; xfer_done = 0;
    hdr_mode = 0; hdr_exit = 0; halt_err = 0; ibi_pending = 0; mr_pending = 0;
    fifo_rst_req = 0;
    sw_enable = 1;
    steps(3);
    check("R10 status after reset", bit_of(en_status), 0);
    check("R10 err after reset", bit_of(req_err), 0);
    rst_n = 1;
    sw_enable = 0;
    steps(2);

    fifo_rst_req = 1; step();
    check("R5 flush while off", bit_of(fifo_flush), 1);
    fifo_rst_req = 0;

    // R7: wake-up needs two SCL edges
    sw_enable = 1; steps(6);
    check("R7 no scl stays off", bit_of(en_status), 0);
    scl_pulse();
    check("R7 one edge not enough", bit_of(en_status), 0);
    scl_pulse();
    check("R7 two edges enable", bit_of(en_status), 1);

    fifo_rst_req = 1; step();
    check("R5 flush ignored while on", bit_of(fifo_flush), 0);
    halt_err = 1; step();
    check("R5 flush allowed when halted", bit_of(fifo_flush), 1);
    halt_err = 0; fifo_rst_req = 0; step();

    // R2: SDR disable waits for transfer end
    xfer_active = 1; sw_enable = 0; step();
    check("R2 nack after request", bit_of(nack_new), 1);
    check("R1 status held", bit_of(en_status), 1);
    scl_pulse(); scl_pulse();
    check("R2 still pending", bit_of(en_status), 1);
    xfer_done = 1; step();
    xfer_done = 0; xfer_active = 0;
    check("R2 off at transfer end", bit_of(en_status), 0);
    step();
    sw_enable = 1; scl_pulse(); scl_pulse();

    // R3: HDR disable waits for Exit
    hdr_mode = 1; sw_enable = 0; step();
    check("R3 no nack in hdr", bit_of(nack_new), 0);
    scl_pulse(); scl_pulse();
    check("R3 status held in hdr", bit_of(en_status), 1);
    hdr_exit = 1; step();
    hdr_exit = 0;
    check("R3 off after exit", bit_of(en_status), 0);
    hdr_mode = 0; step();
    sw_enable = 1; scl_pulse(); scl_pulse();

    // R4/R6: idle disable waits for SCL, no self flush
    sw_enable = 0; steps(12);
    check("R4 idle no scl stays on", bit_of(en_status), 1);
    scl_in = 1; steps(2);
    check("R4 two samples not yet", bit_of(en_status), 1);
    step();
    check("R4 third sample disables", bit_of(en_status), 0);
    check("R6 no self flush", bit_of(fifo_flush), 0);
    scl_in = 0; steps(4);
    sw_enable = 1; scl_pulse(); scl_pulse();

    // R8: refused disable
    ibi_pending = 1; sw_enable = 0; steps(2);
    check("R8 err set on ibi", bit_of(req_err), 1);
    check("R8 stays on", bit_of(en_status), 1);
    ibi_pending = 0; scl_pulse();
    check("R8 no late disable", bit_of(en_status), 1);
    sw_enable = 1; step();
    check("R8 err cleared", bit_of(req_err), 0);
    mr_pending = 1; sw_enable = 0; step();
    check("R8 err set on mr", bit_of(req_err), 1);
    mr_pending = 0; sw_enable = 1; step();

    // R9: cancel a pending disable
    xfer_active = 1; sw_enable = 0; step();
    check("R9 pending nacks", bit_of(nack_new), 1);
    sw_enable = 1; step();
    check("R9 cancel clears nack", bit_of(nack_new), 0);
    check("R9 cancel keeps status", bit_of(en_status), 1);
    xfer_active = 0; step();

    // R7: abort a wake-up
    sw_enable = 0; scl_pulse();
    check("R7 off before abort", bit_of(en_status), 0);
    sw_enable = 1; scl_pulse();
    sw_enable = 0; step();
    check("R7 abort returns off", bit_of(fifo_rst_ok), 1);
    sw_enable = 1; scl_pulse(); scl_pulse();
    check("R7 wake after abort", bit_of(en_status), 1);

    steps(4);
    summary();
  end
endmodule